// File: doc/BRIEF.md
# Three-phase gate control logic

This block is the digital core of a three-phase half-bridge gate driver. It turns PWM requests into six gate commands, one high-side and one low-side per phase, and keeps the two switches of a bridge leg from conducting together. The PWM source supplies either six independent signals or only the three high-side signals. In the second case the block derives each low-side command as the complement of its own phase's high-side input. Every rising gate edge waits for a programmable dead time, counted in system clock cycles.

Per-phase overcurrent comparator flags, and flags for supply and temperature status, arrive as synchronous digital inputs. An overcurrent either cuts the conducting switch for the rest of the current PWM pulse, or latches its whole phase off until the gate enable is cycled. The block chooses between the two with a policy input. Any overcurrent pulls an active-low warning output low for a stretched window; the overtemperature warning flag drives the same output. Supply lockouts, gate-supply lockouts, overtemperature shutdown and latched phase shutdowns appear on an active-low fault output.

Top module: `bridge_gate_top`

## Requirements
- R1: With `threeInMode` low, each gate output follows its own PWM input (`pwmHi[p]` drives `gateHi[p]`, `pwmLo[p]` drives `gateLo[p]`), subject to dead time.
- R2: With `threeInMode` high, `pwmLo` is ignored, and the low-side request of phase p is the inverse of `pwmHi[p]`.
- R3: In six-input mode, when both requests of one phase are high, both gates of that phase are driven off.
- R4: A gate rises only after its request has stayed high, and the opposite gate of its phase has stayed off, for `deadCycles`+1 consecutive clock edges. A gate falls one edge after its request drops.
- R5: `gateHi[p]` and `gateLo[p]` are never high in the same cycle.
- R6: With `ocLatchMode` low, an `ocFlag[p]` seen while a switch of phase p is on turns that switch off one edge later. The switch stays off until its request goes low, and then resumes normal operation.
- R7: With `ocLatchMode` high, `ocFlag[p]` turns off both gates of phase p only, and `faultN` goes low. Both conditions hold until `gateEn` is taken low.
- R8: `warnN` goes low on the edge that samples any `ocFlag` bit and stays low for `STRETCH_CYC` cycles after the last flag (6400 by default, 64 µs at 100 MHz). It is also low while `otWarn` is high.
- R9: While `gateEn` is low, all six gates are off, and latched phase shutdowns and over-current cuts are cleared.
- R10: While any of `pvddUv`, `gvddUv`, `gvddOv` or `otShut` is high, all gates are off from the next edge on, and `faultN` is low from that edge on.
- R11: After reset, all gates are off and `faultN` and `warnN` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmHi | input | 3 | High-side PWM request per phase |
| pwmLo | input | 3 | Low-side PWM request per phase (six-input mode only) |
| threeInMode | input | 1 | 1: low side is the complement of the high-side input |
| ocLatchMode | input | 1 | 0: cut per pulse, 1: latch phase off |
| gateEn | input | 1 | Gate enable; low forces all gates off and clears latches |
| ocFlag | input | 3 | Overcurrent comparator flag per phase |
| pvddUv | input | 1 | Supply undervoltage |
| gvddUv | input | 1 | Gate-supply undervoltage |
| gvddOv | input | 1 | Gate-supply overvoltage |
| otShut | input | 1 | Overtemperature shutdown |
| otWarn | input | 1 | Overtemperature warning |
| deadCycles | input | DT_W (8) | Dead time in clock cycles |
| gateHi | output | 3 | High-side gate command per phase |
| gateLo | output | 3 | Low-side gate command per phase |
| faultN | output | 1 | Active-low fault report |
| warnN | output | 1 | Active-low overcurrent / overtemperature warning |

## Verification
The assertions check, on every cycle, that no leg is ever shorted and that a gate rises only when its partner was already off. They also check that the enable, the lockouts and the two overcurrent policies each turn off the affected gates within their fixed latency, and that a flag pulls the warning low at once. The exact dead-time count, the length of the warning window, the inverted low side in three-input mode, the release of a per-pulse cut on the next request edge, and the isolation of a latched phase from its neighbours all need a sequence of stimulus. Only the bench scenarios show them, with a cycle-accurate model of the requirements.

// File: rtl/bridge_gate_pkg.sv
package bridge_gate_pkg;
  localparam int NPH = 3;

  // Control-to-datapath strobes
  typedef struct packed {
    logic [NPH-1:0] kill;    // latched phase shutdown
    logic [NPH-1:0] blkHi;   // high side cut for this pulse
    logic [NPH-1:0] blkLo;   // low side cut for this pulse
    logic           allOff;  // enable low or any lockout
  } gateStrobe_t;
endpackage

// File: rtl/bridge_gate_deadtime.sv
module bridge_gate_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            want,
  input  logic            otherOn,
  input  logic [DT_W-1:0] dead,
  output logic            gateOut
);
  logic [DT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      gateOut <= 1'b0;
    end else if (!want) begin
      cnt     <= '0;
      gateOut <= 1'b0;
    end else if (otherOn) begin
      cnt <= '0;
    end else if (!gateOut) begin
      if (cnt >= dead) gateOut <= 1'b1;
      else             cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bridge_gate_path.sv
module bridge_gate_path
  import bridge_gate_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NPH-1:0]  pwmHi,
  input  logic [NPH-1:0]  pwmLo,
  input  logic            threeInMode,
  input  logic [DT_W-1:0] deadCycles,
  input  gateStrobe_t     strobe,
  output logic [NPH-1:0]  reqHi,
  output logic [NPH-1:0]  reqLo,
  output logic [NPH-1:0]  gateHi,
  output logic [NPH-1:0]  gateLo
);
  logic [NPH-1:0] clash;
  logic [NPH-1:0] wantHi;
  logic [NPH-1:0] wantLo;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    always_comb begin
      reqHi[p]  = pwmHi[p];
      reqLo[p]  = threeInMode ? ~pwmHi[p] : pwmLo[p];
      clash[p]  = reqHi[p] & reqLo[p];
      wantHi[p] = reqHi[p] & ~clash[p] & ~strobe.allOff & ~strobe.kill[p] & ~strobe.blkHi[p];
      wantLo[p] = reqLo[p] & ~clash[p] & ~strobe.allOff & ~strobe.kill[p] & ~strobe.blkLo[p];
    end

    bridge_gate_deadtime #(.DT_W(DT_W)) u_dtHi (
      .clk(clk), .rstN(rstN), .want(wantHi[p]), .otherOn(gateLo[p]),
      .dead(deadCycles), .gateOut(gateHi[p])
    );

    bridge_gate_deadtime #(.DT_W(DT_W)) u_dtLo (
      .clk(clk), .rstN(rstN), .want(wantLo[p]), .otherOn(gateHi[p]),
      .dead(deadCycles), .gateOut(gateLo[p])
    );
  end
endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
  import bridge_gate_pkg::*;
#(
  parameter int STRETCH_CYC = 6400
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           gateEn,
  input  logic           ocLatchMode,
  input  logic [NPH-1:0] ocFlag,
  input  logic           pvddUv,
  input  logic           gvddUv,
  input  logic           gvddOv,
  input  logic           otShut,
  input  logic           otWarn,
  input  logic [NPH-1:0] reqHi,
  input  logic [NPH-1:0] reqLo,
  input  logic [NPH-1:0] gateHi,
  input  logic [NPH-1:0] gateLo,
  output gateStrobe_t    strobe,
  output logic           faultN,
  output logic           warnN
);
  localparam int SW = $clog2(STRETCH_CYC + 1);
  localparam logic [SW-1:0] STRETCH_LOAD = SW'(STRETCH_CYC);

  logic [NPH-1:0] killQ, blkHiQ, blkLoQ;
  logic [SW-1:0]  stretchQ;
  logic           faultQ;
  logic           lockout;

  assign lockout = pvddUv | gvddUv | gvddOv | otShut;

  for (genvar p = 0; p < NPH; p++) begin : g_oc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        killQ[p]  <= 1'b0;
        blkHiQ[p] <= 1'b0;
        blkLoQ[p] <= 1'b0;
      end else if (!gateEn) begin
        killQ[p]  <= 1'b0;
        blkHiQ[p] <= 1'b0;
        blkLoQ[p] <= 1'b0;
      end else begin
        killQ[p] <= killQ[p] | (ocLatchMode & ocFlag[p]);
        if (!ocLatchMode && ocFlag[p] && gateHi[p]) blkHiQ[p] <= 1'b1;
        else if (!reqHi[p])                         blkHiQ[p] <= 1'b0;
        if (!ocLatchMode && ocFlag[p] && gateLo[p]) blkLoQ[p] <= 1'b1;
        else if (!reqLo[p])                         blkLoQ[p] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stretchQ <= '0;
      faultQ   <= 1'b0;
    end else begin
      if (|ocFlag)             stretchQ <= STRETCH_LOAD;
      else if (stretchQ != '0) stretchQ <= stretchQ - 1'b1;
      faultQ <= lockout | (|killQ);
    end
  end

  always_comb begin
    strobe.kill   = killQ;
    strobe.blkHi  = blkHiQ;
    strobe.blkLo  = blkLoQ;
    strobe.allOff = ~gateEn | lockout;
    faultN        = ~faultQ;
    warnN         = ~((stretchQ != '0) | otWarn);
  end
endmodule

// File: rtl/bridge_gate_top.sv
module bridge_gate_top
  import bridge_gate_pkg::*;
#(
  parameter int DT_W        = 8,
  parameter int STRETCH_CYC = 6400
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      pwmHi,
  input  logic [2:0]      pwmLo,
  input  logic            threeInMode,
  input  logic            ocLatchMode,
  input  logic            gateEn,
  input  logic [2:0]      ocFlag,
  input  logic            pvddUv,
  input  logic            gvddUv,
  input  logic            gvddOv,
  input  logic            otShut,
  input  logic            otWarn,
  input  logic [DT_W-1:0] deadCycles,
  output logic [2:0]      gateHi,
  output logic [2:0]      gateLo,
  output logic            faultN,
  output logic            warnN
);
  gateStrobe_t    strobe;
  logic [NPH-1:0] reqHi, reqLo;

  bridge_gate_ctrl #(.STRETCH_CYC(STRETCH_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .gateEn(gateEn), .ocLatchMode(ocLatchMode),
    .ocFlag(ocFlag), .pvddUv(pvddUv), .gvddUv(gvddUv), .gvddOv(gvddOv),
    .otShut(otShut), .otWarn(otWarn), .reqHi(reqHi), .reqLo(reqLo),
    .gateHi(gateHi), .gateLo(gateLo), .strobe(strobe),
    .faultN(faultN), .warnN(warnN)
  );

  bridge_gate_path #(.DT_W(DT_W)) u_path (
    .clk(clk), .rstN(rstN), .pwmHi(pwmHi), .pwmLo(pwmLo),
    .threeInMode(threeInMode), .deadCycles(deadCycles), .strobe(strobe),
    .reqHi(reqHi), .reqLo(reqLo), .gateHi(gateHi), .gateLo(gateLo)
  );
endmodule

// File: rtl/bridge_gate_chk.sv
module bridge_gate_chk (
  input logic       clk,
  input logic       rstN,
  input logic       gateEn,
  input logic       ocLatchMode,
  input logic [2:0] ocFlag,
  input logic       pvddUv,
  input logic       gvddUv,
  input logic       gvddOv,
  input logic       otShut,
  input logic [2:0] gateHi,
  input logic [2:0] gateLo,
  input logic       faultN,
  input logic       warnN
);
  for (genvar p = 0; p < 3; p++) begin : g_ph
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
      !(gateHi[p] && gateLo[p]));

    a_r4_hi_after_lo_off: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateHi[p]) |-> !$past(gateLo[p]));

    a_r4_lo_after_hi_off: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateLo[p]) |-> !$past(gateHi[p]));

    a_r6_cycle_cut: assert property (@(posedge clk) disable iff (!rstN)
      (gateEn && !ocLatchMode && ocFlag[p] && gateHi[p]) |=> ##1 !gateHi[p]);

    a_r7_latch_off: assert property (@(posedge clk) disable iff (!rstN)
      (gateEn && ocLatchMode && ocFlag[p]) |=> ##1 (!gateHi[p] && !gateLo[p] && !faultN));
  end

  a_r9_enable_off: assert property (@(posedge clk) disable iff (!rstN)
    !gateEn |=> (gateHi == 3'b000 && gateLo == 3'b000));

  a_r10_lockout_off: assert property (@(posedge clk) disable iff (!rstN)
    (pvddUv || gvddUv || gvddOv || otShut) |=> (gateHi == 3'b000 && gateLo == 3'b000 && !faultN));

  a_r8_warn_on_oc: assert property (@(posedge clk) disable iff (!rstN)
    (ocFlag != 3'b000) |=> !warnN);
endmodule

bind bridge_gate_top bridge_gate_chk u_chk (
  .clk(clk), .rstN(rstN), .gateEn(gateEn), .ocLatchMode(ocLatchMode),
  .ocFlag(ocFlag), .pvddUv(pvddUv), .gvddUv(gvddUv), .gvddOv(gvddOv),
  .otShut(otShut), .gateHi(gateHi), .gateLo(gateLo),
  .faultN(faultN), .warnN(warnN)
);

// File: tb/bridge_gate_top_bench.sv
module bridge_gate_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STRETCH    = 100;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] pwmHi = '0, pwmLo = '0, ocFlag = '0;
  logic       threeInMode = 0, ocLatchMode = 0, gateEn = 0;
  logic       pvddUv = 0, gvddUv = 0, gvddOv = 0, otShut = 0, otWarn = 0;
  logic [7:0] deadCycles = 8'd0;
  logic [2:0] gateHi, gateLo;
  logic       faultN, warnN;

  int    nChecks = 0;
  int    nFail = 0;
  string curTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_gate_top #(.DT_W(8), .STRETCH_CYC(STRETCH)) u_bridge_gate_top (
    .clk(clk), .rstN(rstN), .pwmHi(pwmHi), .pwmLo(pwmLo),
    .threeInMode(threeInMode), .ocLatchMode(ocLatchMode), .gateEn(gateEn),
    .ocFlag(ocFlag), .pvddUv(pvddUv), .gvddUv(gvddUv), .gvddOv(gvddOv),
    .otShut(otShut), .otWarn(otWarn), .deadCycles(deadCycles),
    .gateHi(gateHi), .gateLo(gateLo), .faultN(faultN), .warnN(warnN)
  );

  // ---------------- reference model built from the requirements ----------------
  logic [2:0] mHi, mLo, mKill, mBH, mBL;
  logic [7:0] mCh [3];
  logic [7:0] mCl [3];
  int         mStr;
  logic       mFault;

  function automatic logic [8:0] dtStep(logic want, logic other, logic out,
                                        logic [7:0] cnt, logic [7:0] dead);
    if (!want)         return 9'd0;
    else if (other)    return {out, 8'd0};
    else if (out)      return {1'b1, cnt};
    else if (cnt >= dead) return {1'b1, cnt};
    else               return {1'b0, cnt + 8'd1};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mHi = '0; mLo = '0; mKill = '0; mBH = '0; mBL = '0;
      mStr = 0; mFault = 1'b0;
      for (int p = 0; p < 3; p++) begin mCh[p] = '0; mCl[p] = '0; end
    end else begin
      logic       off, rh, rl, wh, wl;
      logic [8:0] sh, sl;
      logic [2:0] nHi, nLo, nKill, nBH, nBL;
      off = !gateEn | pvddUv | gvddUv | gvddOv | otShut;
      for (int p = 0; p < 3; p++) begin
        rh = pwmHi[p];
        rl = threeInMode ? !pwmHi[p] : pwmLo[p];
        wh = rh & !(rh & rl) & !off & !mKill[p] & !mBH[p];
        wl = rl & !(rh & rl) & !off & !mKill[p] & !mBL[p];
        sh = dtStep(wh, mLo[p], mHi[p], mCh[p], deadCycles);
        sl = dtStep(wl, mHi[p], mLo[p], mCl[p], deadCycles);
        nHi[p] = sh[8]; mCh[p] = sh[7:0];
        nLo[p] = sl[8]; mCl[p] = sl[7:0];
        if (!gateEn) begin
          nKill[p] = 0; nBH[p] = 0; nBL[p] = 0;
        end else begin
          nKill[p] = mKill[p] | (ocLatchMode & ocFlag[p]);
          nBH[p] = (!ocLatchMode && ocFlag[p] && mHi[p]) ? 1'b1 : (rh ? mBH[p] : 1'b0);
          nBL[p] = (!ocLatchMode && ocFlag[p] && mLo[p]) ? 1'b1 : (rl ? mBL[p] : 1'b0);
        end
      end
      mFault = (pvddUv | gvddUv | gvddOv | otShut) | (|mKill);
      if (ocFlag != 0) mStr = STRETCH; else if (mStr > 0) mStr = mStr - 1;
      mHi = nHi; mLo = nLo; mKill = nKill; mBH = nBH; mBL = nBL;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk({gateHi, gateLo} == {mHi, mLo}, curTag, {gateHi, gateLo}, {mHi, mLo});
    chk(faultN == !mFault, "R10 faultN", faultN, !mFault);
    chk(warnN == !((mStr != 0) || otWarn), "R8 warnN", warnN, !((mStr != 0) || otWarn));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic runRandom(input int n, input string tag, input int ocRate,
                           input int lockRate, input int enRate);
    curTag = tag;
    for (int i = 0; i < n; i++) begin
      tick();
      for (int b = 0; b < 3; b++) begin
        if ($urandom % 12 == 0) pwmHi[b] = ~pwmHi[b];
        if ($urandom % 12 == 0) pwmLo[b] = ~pwmLo[b];
      end
      ocFlag = '0;
      if (ocRate > 0 && $urandom % ocRate == 0) ocFlag[$urandom % 3] = 1'b1;
      if (lockRate > 0) begin
        if ($urandom % lockRate == 0) pvddUv = ~pvddUv;
        if ($urandom % lockRate == 0) gvddUv = ~gvddUv;
        if ($urandom % lockRate == 0) gvddOv = ~gvddOv;
        if ($urandom % lockRate == 0) otShut = ~otShut;
        if ($urandom % lockRate == 0) otWarn = ~otWarn;
      end
      if (enRate > 0 && $urandom % enRate == 0) gateEn = ~gateEn;
    end
    ocFlag = '0; pvddUv = 0; gvddUv = 0; gvddOv = 0; otShut = 0; otWarn = 0;
    gateEn = 1'b1;
    idle(STRETCH + 4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk(gateHi == 0 && gateLo == 0, "R11 gates", {gateHi, gateLo}, 0);
    chk(faultN == 1 && warnN == 1, "R11 flags", {faultN, warnN}, 2'b11);
    rstN = 1'b1;
    gateEn = 1'b1;
    deadCycles = 8'd4;
    idle(4);

    // R4: exact dead-time count from an idle leg
    curTag = "R4";
    pwmHi[0] = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin tick(); n++; if (gateHi[0]) break; end
    chk(n == 5, "R4 rise delay", n, 5);
    pwmHi[0] = 1'b0; tick();
    chk(gateHi[0] == 0, "R4 fall one edge", gateHi[0], 0);
    idle(3);

    // R3: both requests high in six-input mode
    curTag = "R3";
    pwmHi[2] = 1; pwmLo[2] = 1; idle(8);
    chk(gateHi[2] == 0 && gateLo[2] == 0, "R3 clash off", {gateHi[2], gateLo[2]}, 0);
    pwmHi = 0; pwmLo = 0; idle(3);

    // R2: three-input mode ignores low-side inputs
    curTag = "R2";
    threeInMode = 1; pwmLo = 3'b111; pwmHi = 3'b001; idle(12);
    chk(gateHi == 3'b001 && gateLo == 3'b110, "R2 complement", {gateHi, gateLo}, 6'b001110);
    pwmLo = 3'b000; idle(3);
    chk(gateLo == 3'b110, "R2 pwmLo ignored", gateLo, 3'b110);
    threeInMode = 0; pwmHi = 0; idle(8);

    // R8: warning stretch length
    curTag = "R8";
    ocFlag[1] = 1; tick(); ocFlag = 0;
    n = 0;
    for (int i = 0; i < STRETCH + 20; i++) begin if (warnN) break; n++; tick(); end
    chk(n == STRETCH, "R8 stretch length", n, STRETCH);
    otWarn = 1; tick();
    chk(warnN == 0, "R8 otWarn", warnN, 0);
    otWarn = 0; idle(2);

    // R7: latched shutdown of one phase only
    curTag = "R7";
    ocLatchMode = 1; deadCycles = 2;
    pwmHi = 3'b010; pwmLo = 3'b001; idle(8);
    ocFlag[1] = 1; tick(); ocFlag = 0; idle(3);
    chk(gateHi[1] == 0, "R7 phase off", gateHi[1], 0);
    chk(gateLo[0] == 1, "R7 neighbour on", gateLo[0], 1);
    chk(faultN == 0, "R7 fault", faultN, 0);
    pwmHi[1] = 0; pwmLo[1] = 1; idle(8);
    chk(gateLo[1] == 0, "R7 held off", gateLo[1], 0);
    // R9: enable cycle clears the latch
    curTag = "R9";
    gateEn = 0; tick();
    chk(gateLo == 0 && gateHi == 0, "R9 enable off", {gateHi, gateLo}, 0);
    gateEn = 1; idle(8);
    chk(gateLo[1] == 1 && faultN == 1, "R9 latch cleared", {gateLo[1], faultN}, 2'b11);

    // R6: per-pulse cut, released on the next request edge
    curTag = "R6";
    ocLatchMode = 0; pwmHi = 3'b100; pwmLo = 0; idle(8);
    ocFlag[2] = 1; tick(); ocFlag = 0; idle(2);
    chk(gateHi[2] == 0, "R6 cut", gateHi[2], 0);
    pwmHi[2] = 0; tick(); pwmHi[2] = 1; idle(6);
    chk(gateHi[2] == 1, "R6 resume", gateHi[2], 1);
    pwmHi = 0; idle(3);

    // R10: lockout forces all off and reports a fault
    curTag = "R10";
    pwmHi = 3'b101; pwmLo = 3'b010; idle(8);
    gvddOv = 1; tick();
    chk(gateHi == 0 && gateLo == 0 && faultN == 0, "R10 lockout",
        {gateHi, gateLo, faultN}, 0);
    gvddOv = 0; idle(8);
    chk(gateHi == 3'b101 && gateLo == 3'b010 && faultN == 1, "R10 release",
        {gateHi, gateLo, faultN}, 7'b1010101);
    pwmHi = 0; pwmLo = 0; idle(3);

    // random phases
    deadCycles = 3; runRandom(3000, "R1 R5 six-input", 0, 0, 0);
    threeInMode = 1; deadCycles = 5; runRandom(3000, "R2 R4 three-input", 0, 0, 0);
    threeInMode = 0; deadCycles = 1; runRandom(3000, "R6 cycle oc", 40, 0, 0);
    ocLatchMode = 1; runRandom(3000, "R7 latched oc", 200, 0, 60);
    ocLatchMode = 0; deadCycles = 0; runRandom(3000, "R9 R10 enable lockout", 150, 80, 90);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule